// File: doc/BRIEF.md
# Mode-Banked Register File with Status Registers

This block is the architectural register store of a 32-bit processor core. It has sixteen logical registers, addressed by a 4-bit index. The physical register behind an index depends on the operating mode held in the current status word. Two read ports are combinational. One write port updates storage on the rising clock edge. The block also holds the current status word and five saved status words, one for each exception mode, and presents the condition flags of the current status word.

The current mode field acts as the state of a small controller. Each clock edge performs one status action, chosen by priority:
- ACT_ENTER: an exception-entry strobe with a valid target mode.
- ACT_LOAD: a write of the whole current status word.
- ACT_SWITCH: a mode-change request, which replaces only the mode field.
- ACT_HOLD: none of the above.

The pipeline reads and writes registers through the index ports. Privileged code reaches the status words through the status write ports.

Mode encodings (bits [4:0] of the status word):
- user 10000
- fast-interrupt 10001
- interrupt 10010
- supervisor 10011
- abort 10111
- undefined 11011
- system 11111

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register reads zero and the current status reads 0x000000DF. That value is system mode, bit 5 (instruction state) clear, and the fast-interrupt mask (bit 6) and interrupt mask (bit 7) both set. Every saved status word is zero.
- R2: Both read ports return the addressed register combinationally. A write on the write port becomes visible from the next clock edge, and a read of the same index in the write cycle still returns the old value.
- R3: In fast-interrupt mode (10001), logical indices 8 to 14 use a private bank of seven registers. In any other mode those indices reach the shared copies.
- R4: Supervisor, abort, interrupt and undefined modes each have their own private copies of indices 13 and 14. Indices 0 to 12 and 15 are shared with user mode.
- R5: User and system mode use the same unbanked set. A mode field holding none of the seven encodings banks as user mode.
- R6: Any value written to the current or a saved status word is stored ANDed with 0xF00000FF, so bits [27:8] always read zero.
- R7: In one clock edge, an exception-entry strobe with a target of fast-interrupt, supervisor, abort, interrupt or undefined mode does three things. It copies the current status into that mode's saved status word. It sets the mode field to the target. It sets bit 7, and it also sets bit 6 when the target is fast-interrupt mode. All other bits are left unchanged.
- R8: An exception-entry strobe whose target is user, system or an unrecognised encoding has no effect.
- R9: In user, system or an unrecognised mode, the saved status port returns the current status word, and a saved status write is ignored.
- R10: A register write and a status change of mode in the same cycle both take effect. The register write lands in the bank of the mode that was active before the edge.
- R11: Status actions take priority in this order: exception entry, then full current-status write, then mode-change request. A saved status write in the same cycle as an accepted exception entry is dropped.
- R12: The flag output presents bits 31, 30, 29 and 28 of the current status word (negative, zero, carry, overflow), in that order from its MSB.
- R13: A mode-change request replaces bits [4:0] of the current status word with the requested value and leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Register write data |
| mode_req_en | input | 1 | Mode-change request |
| mode_req_val | input | 5 | Requested mode field |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of exception entry |
| cpsr_wr_en | input | 1 | Current status write enable |
| cpsr_wr_data | input | 32 | Current status write data |
| spsr_wr_en | input | 1 | Saved status write enable (current mode's word) |
| spsr_wr_data | input | 32 | Saved status write data |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved status word of the current mode |
| flags_nzcv | output | 4 | Condition flags {N,Z,C,V} |

## Verification
Several functions can land on the same clock edge:
- A register write and a mode change: the bench drives a write to index 13 in the same cycle as a status write that leaves supervisor mode. It then reads index 13 in both modes to show that the data went to the old bank.
- Exception entry and the other status actions: the bench fires all status actions in one cycle. The behavioural model, which applies the priority order independently, judges the resulting status word and the saved status word on every following clock.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int          IDX_W     = 4;
    localparam int          N_VIS     = 1 << IDX_W;
    localparam int          PSR_W     = 32;
    localparam logic [31:0] PSR_KEEP  = 32'hF000_00FF;
    localparam logic [31:0] PSR_RESET = 32'h0000_00DF;
    localparam int          FAST_LO   = 8;
    localparam int          FAST_N    = 7;
    localparam int          PAIR_LO   = 13;
    localparam int          PAIR_N    = 2;
    localparam int          N_PAIRS   = 4;
    localparam int          N_SAVED   = 5;
    localparam int          N_PHYS    = N_VIS + FAST_N + N_PAIRS * PAIR_N;
    localparam int          PHYS_W    = $clog2(N_PHYS);
    localparam logic [2:0]  SLOT_NONE = 3'd7;

    typedef enum logic [4:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    // pair banks must stay contiguous from BK_IRQ upward
    typedef enum logic [2:0] {
        BK_COMMON, BK_FAST, BK_IRQ, BK_SVC, BK_ABT, BK_UND
    } bank_e;

    typedef enum logic [1:0] {
        ACT_HOLD, ACT_ENTER, ACT_LOAD, ACT_SWITCH
    } act_e;

    function automatic bank_e bank_of(logic [4:0] m);
        case (m)
            MD_FIQ:  return BK_FAST;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_COMMON;
        endcase
    endfunction

    function automatic logic [2:0] saved_slot(logic [4:0] m);
        case (m)
            MD_FIQ:  return 3'd0;
            MD_SVC:  return 3'd1;
            MD_ABT:  return 3'd2;
            MD_IRQ:  return 3'd3;
            MD_UND:  return 3'd4;
            default: return SLOT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_pkg::*;
(
    input  logic [4:0]        mode,
    input  logic [IDX_W-1:0]  lidx,
    output logic [PHYS_W-1:0] pidx
);

    bank_e bk;
    int    li;
    int    v;

    always_comb begin
        bk   = bank_of(mode);
        li   = int'(lidx);
        v    = li;
        case (bk)
            BK_COMMON: v = li;
            BK_FAST: begin
                if (li >= FAST_LO && li < FAST_LO + FAST_N)
                    v = N_VIS + li - FAST_LO;
            end
            default: begin
                if (li >= PAIR_LO && li < PAIR_LO + PAIR_N)
                    v = N_VIS + FAST_N + (int'(bk) - int'(BK_IRQ)) * PAIR_N + li - PAIR_LO;
            end
        endcase
        pidx = PHYS_W'(v);
    end

endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store #(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int N_SLOTS = 1 << AW;

    logic [DATA_W-1:0] mem [N_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rf_status.sv
module rf_status
    import rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_en,
    input  logic [4:0]       exc_mode,
    input  logic             cpsr_wr_en,
    input  logic [PSR_W-1:0] cpsr_wr_data,
    input  logic             mode_req_en,
    input  logic [4:0]       mode_req_val,
    input  logic             spsr_wr_en,
    input  logic [PSR_W-1:0] spsr_wr_data,
    output logic [PSR_W-1:0] cpsr_q,
    output logic [PSR_W-1:0] spsr_q
);

    logic [PSR_W-1:0] cpsr_r, cpsr_n;
    logic [PSR_W-1:0] saved_r [N_SAVED];
    logic [2:0]       cur_slot, tgt_slot;
    act_e             act;

    assign cur_slot = saved_slot(cpsr_r[4:0]);
    assign tgt_slot = saved_slot(exc_mode);

    // action selection, highest priority first
    always_comb begin
        if (exc_en && tgt_slot != SLOT_NONE) act = ACT_ENTER;
        else if (cpsr_wr_en)                 act = ACT_LOAD;
        else if (mode_req_en)                act = ACT_SWITCH;
        else                                 act = ACT_HOLD;
    end

    always_comb begin
        cpsr_n = cpsr_r;
        unique case (act)
            ACT_ENTER: begin
                cpsr_n[4:0] = exc_mode;
                cpsr_n[7]   = 1'b1;
                if (exc_mode == MD_FIQ) cpsr_n[6] = 1'b1;
            end
            ACT_LOAD:   cpsr_n      = cpsr_wr_data & PSR_KEEP;
            ACT_SWITCH: cpsr_n[4:0] = mode_req_val;
            ACT_HOLD:   cpsr_n      = cpsr_r;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpsr_r <= PSR_RESET;
        else        cpsr_r <= cpsr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_SAVED; k++) saved_r[k] <= '0;
        end else begin
            for (int k = 0; k < N_SAVED; k++) begin
                if (act == ACT_ENTER && tgt_slot == 3'(k))
                    saved_r[k] <= cpsr_r;
                else if (act != ACT_ENTER && spsr_wr_en && cur_slot == 3'(k))
                    saved_r[k] <= spsr_wr_data & PSR_KEEP;
            end
        end
    end

    always_comb begin
        spsr_q = cpsr_r;
        for (int k = 0; k < N_SAVED; k++)
            if (cur_slot == 3'(k)) spsr_q = saved_r[k];
    end

    assign cpsr_q = cpsr_r;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_req_en,
    input  logic [4:0]        mode_req_val,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    input  logic              cpsr_wr_en,
    input  logic [31:0]       cpsr_wr_data,
    input  logic              spsr_wr_en,
    input  logic [31:0]       spsr_wr_data,
    output logic [31:0]       cpsr_q,
    output logic [31:0]       spsr_q,
    output logic [3:0]        flags_nzcv
);

    localparam int N_PORTS = 3;

    logic [IDX_W-1:0]  lidx [N_PORTS];
    logic [PHYS_W-1:0] pidx [N_PORTS];

    assign lidx[0] = rd_a_idx;
    assign lidx[1] = rd_b_idx;
    assign lidx[2] = wr_idx;

    // one index translator per port, all driven by the pre-edge mode
    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        rf_bank_map u_map (
            .mode (cpsr_q[4:0]),
            .lidx (lidx[p]),
            .pidx (pidx[p])
        );
    end

    rf_gpr_store #(
        .DATA_W (DATA_W),
        .AW     (PHYS_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (pidx[2]),
        .wdata   (wr_data),
        .raddr_a (pidx[0]),
        .rdata_a (rd_a_data),
        .raddr_b (pidx[1]),
        .rdata_b (rd_b_data)
    );

    rf_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_en       (exc_en),
        .exc_mode     (exc_mode),
        .cpsr_wr_en   (cpsr_wr_en),
        .cpsr_wr_data (cpsr_wr_data),
        .mode_req_en  (mode_req_en),
        .mode_req_val (mode_req_val),
        .spsr_wr_en   (spsr_wr_en),
        .spsr_wr_data (spsr_wr_data),
        .cpsr_q       (cpsr_q),
        .spsr_q       (spsr_q)
    );

    assign flags_nzcv = cpsr_q[31:28];

endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exc_en,
    input logic [4:0]  exc_mode,
    input logic        cpsr_wr_en,
    input logic        mode_req_en,
    input logic [31:0] cpsr_q,
    input logic [31:0] spsr_q
);

    logic tgt_ok;
    assign tgt_ok = saved_slot(exc_mode) != SLOT_NONE;

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_q[27:8] == 20'd0 && spsr_q[27:8] == 20'd0);

    // R7
    enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en && tgt_ok |=> cpsr_q[4:0] == $past(exc_mode) && cpsr_q[7]);

    // R7
    enter_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en && tgt_ok |=> spsr_q == $past(cpsr_q));

    // R8
    bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en && !tgt_ok && !cpsr_wr_en && !mode_req_en |=> $stable(cpsr_q));

    // R9
    shared_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_q[4:0] == MD_USR || cpsr_q[4:0] == MD_SYS) |-> spsr_q == cpsr_q);

endmodule

bind banked_regfile rf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_en      (exc_en),
    .exc_mode    (exc_mode),
    .cpsr_wr_en  (cpsr_wr_en),
    .mode_req_en (mode_req_en),
    .cpsr_q      (cpsr_q),
    .spsr_q      (spsr_q)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [3:0]  ra, rb, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, cpsr_wr_data, spsr_wr_data, cpsr_q, spsr_q;
    logic        wr_en, mode_req_en, exc_en, cpsr_wr_en, spsr_wr_en;
    logic [4:0]  mode_req_val, exc_mode;
    logic [3:0]  flags_nzcv;

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ra), .rd_a_data(rd_a_data),
        .rd_b_idx(rb), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mode_req_en(mode_req_en), .mode_req_val(mode_req_val),
        .exc_en(exc_en), .exc_mode(exc_mode),
        .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
        .cpsr_q(cpsr_q), .spsr_q(spsr_q), .flags_nzcv(flags_nzcv)
    );

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    logic [31:0] sh [16];
    logic [31:0] fq [7];
    logic [31:0] pb [4][2];
    logic [31:0] sv [5];
    logic [31:0] mc;

    function automatic int sslot(logic [4:0] m);
        if (m == FIQ) return 0;
        if (m == SVC) return 1;
        if (m == ABT) return 2;
        if (m == IRQ) return 3;
        if (m == UND) return 4;
        return -1;
    endfunction

    function automatic int pair_of(logic [4:0] m);
        if (m == IRQ) return 0;
        if (m == SVC) return 1;
        if (m == ABT) return 2;
        if (m == UND) return 3;
        return -1;
    endfunction

    function automatic logic [31:0] mread(int i, logic [4:0] m);
        if (m == FIQ && i >= 8 && i <= 14) return fq[i-8];
        if (pair_of(m) >= 0 && i >= 13 && i <= 14) return pb[pair_of(m)][i-13];
        return sh[i];
    endfunction

    task automatic mwrite(int i, logic [4:0] m, logic [31:0] d);
        if (m == FIQ && i >= 8 && i <= 14) fq[i-8] = d;
        else if (pair_of(m) >= 0 && i >= 13 && i <= 14) pb[pair_of(m)][i-13] = d;
        else sh[i] = d;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        logic [4:0] m;
        int s;
        #2;
        m = mc[4:0];
        s = sslot(m);
        chk(tag, "read A", rd_a_data, mread(int'(ra), m));
        chk(tag, "read B", rd_b_data, mread(int'(rb), m));
        chk(tag, "current status", cpsr_q, mc);
        chk(tag, "saved status", spsr_q, (s >= 0) ? sv[s] : mc);
        chk(tag, "flags", {28'd0, flags_nzcv}, {28'd0, mc[31:28]});
        @(posedge clk);
        if (wr_en) mwrite(int'(wr_idx), m, wr_data);
        if (exc_en && sslot(exc_mode) >= 0) begin
            sv[sslot(exc_mode)] = mc;
            mc[4:0] = exc_mode;
            mc[7] = 1'b1;
            if (exc_mode == FIQ) mc[6] = 1'b1;
        end else begin
            if (spsr_wr_en && s >= 0) sv[s] = spsr_wr_data & 32'hF000_00FF;
            if (cpsr_wr_en) mc = cpsr_wr_data & 32'hF000_00FF;
            else if (mode_req_en) mc[4:0] = mode_req_val;
        end
        @(negedge clk);
        wr_en = 0; mode_req_en = 0; exc_en = 0; cpsr_wr_en = 0; spsr_wr_en = 0;
    endtask

    task automatic setmode(logic [4:0] m, string tag);
        mode_req_en = 1; mode_req_val = m; cyc(tag);
    endtask

    task automatic wr(int i, logic [31:0] d, string tag);
        wr_en = 1; wr_idx = 4'(i); wr_data = d; ra = 4'(i); cyc(tag);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 16; i += 2) begin
            ra = 4'(i); rb = 4'(i + 1); cyc(tag);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) sh[i] = '0;
        for (int i = 0; i < 7; i++) fq[i] = '0;
        for (int i = 0; i < 4; i++) begin pb[i][0] = '0; pb[i][1] = '0; end
        for (int i = 0; i < 5; i++) sv[i] = '0;
        mc = 32'h0000_00DF;
        rst_n = 0; ra = 0; rb = 0; wr_idx = 0; wr_data = 0;
        wr_en = 0; mode_req_en = 0; exc_en = 0; cpsr_wr_en = 0; spsr_wr_en = 0;
        mode_req_val = 0; exc_mode = 0; cpsr_wr_data = 0; spsr_wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        sweep("R1");

        // R2 shared writes, read in write cycle shows old value
        for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 + i * 32'h0101, "R2");
        sweep("R2");

        // R13 mode request, R5 user and system share
        setmode(USR, "R13");
        sweep("R5");
        wr(13, 32'hCAFE_0013, "R5");
        setmode(SYS, "R5");
        sweep("R5");

        // R3 fast-interrupt bank
        setmode(FIQ, "R3");
        sweep("R3");
        for (int i = 8; i <= 14; i++) wr(i, 32'hF100_0000 + i, "R3");
        sweep("R3");
        setmode(USR, "R3");
        sweep("R3");
        setmode(FIQ, "R3");
        sweep("R3");

        // R4 pair banks
        begin
            logic [4:0] pm [4];
            pm[0] = SVC; pm[1] = ABT; pm[2] = IRQ; pm[3] = UND;
            for (int k = 0; k < 4; k++) begin
                setmode(pm[k], "R4");
                wr(13, 32'h5000_0000 + k * 16 + 13, "R4");
                wr(14, 32'h5000_0000 + k * 16 + 14, "R4");
                wr(12, 32'h5000_0000 + k * 16 + 12, "R4");
                sweep("R4");
            end
        end

        // R5 unrecognised modes bank as user
        setmode(5'b00000, "R5");
        sweep("R5");
        setmode(5'b10100, "R5");
        sweep("R5");

        // R6 current status masking (lands in system mode)
        cpsr_wr_en = 1; cpsr_wr_data = 32'hFFFF_FF1F; cyc("R6");
        // R9 saved status write ignored in system mode
        spsr_wr_en = 1; spsr_wr_data = 32'h0000_1234; cyc("R9");
        cyc("R9");

        // R12 flags
        cpsr_wr_en = 1; cpsr_wr_data = 32'hA000_0013; cyc("R12");
        cyc("R12");

        // R7 exception entry into interrupt mode
        exc_en = 1; exc_mode = IRQ; cyc("R7");
        cyc("R7");
        sweep("R7");
        spsr_wr_en = 1; spsr_wr_data = 32'hFFFF_FFFF; cyc("R6");
        cyc("R6");
        exc_en = 1; exc_mode = FIQ; cyc("R7");
        cyc("R7");

        // R8 invalid exception targets
        exc_en = 1; exc_mode = USR; cyc("R8");
        exc_en = 1; exc_mode = SYS; cyc("R8");
        exc_en = 1; exc_mode = 5'b00011; cyc("R8");
        cyc("R8");

        // R11 all status actions together
        exc_en = 1; exc_mode = UND;
        cpsr_wr_en = 1; cpsr_wr_data = 32'h0000_0010;
        spsr_wr_en = 1; spsr_wr_data = 32'h0000_0005;
        mode_req_en = 1; mode_req_val = USR;
        cyc("R11");
        cyc("R11");
        cpsr_wr_en = 1; cpsr_wr_data = 32'h6000_0093;
        mode_req_en = 1; mode_req_val = USR;
        cyc("R11");
        cyc("R11");

        // R10 register write with mode change on the same edge
        wr_en = 1; wr_idx = 13; wr_data = 32'hDEAD_0010;
        cpsr_wr_en = 1; cpsr_wr_data = 32'h0000_0010;
        cyc("R10");
        ra = 13; rb = 14; cyc("R10");
        setmode(SVC, "R10");
        ra = 13; cyc("R10");
        wr_en = 1; wr_idx = 14; wr_data = 32'hBEEF_0014;
        mode_req_en = 1; mode_req_val = FIQ;
        cyc("R10");
        ra = 13; rb = 14; cyc("R10");
        setmode(SVC, "R10");
        ra = 13; rb = 14; cyc("R10");

        summary();
        $finish;
    end

endmodule